// File: doc/BRIEF.md
# Octal DAC Serial Command Front End

This block is the digital front end of an eight-channel DAC. A host sends 16-bit command frames over a three-wire serial port made of a serial clock, an active-low frame select and a data line. The block brings these lines into its system clock domain and assembles each frame from the falling edges of the serial clock. A complete frame either loads one channel's staging (input) register or switches the shared power-down state.

Each channel has a staging register and an output (DAC) register. A transfer strobe copies every staging register into its output register at once. When power-down is active, the output codes read as zero. The registers keep their contents during power-down and can still be written. The code resolution is set by a parameter to 8, 10 or 12 bits, and the unused low bits of a narrower variant are cleared when a channel is written.

Top module: `octal_dac_frontend`

## Requirements
- R1: After reset, every channel's staging and output register holds zero, all output codes read zero, and `powered_down` is 0.
- R2: A frame is 16 bits, taken MSB first on falling edges of `ser_clk` while `ser_sel_n` is low. When bit 15 is 0, bits 14:12 select the channel in binary (000 is channel 0, 111 is channel 7) and bits 11:0 are loaded into that channel's staging register once `ser_sel_n` rises.
- R3: If `ser_sel_n` rises after fewer than 16 falling edges, the frame is dropped and no register changes. The next frame starts again from bit 15.
- R4: Falling edges after the 16th, while `ser_sel_n` is still low, are ignored.
- R5: An output code changes only on a `xfer_strobe` pulse or on a change of the power-down state. One strobe copies all eight staging registers into the output registers.
- R6: With `RES_BITS` = 10, bits 1:0 of a written code are cleared. With `RES_BITS` = 8, bits 3:0 are cleared. With 12, all bits are kept.
- R7: A frame with bit 15 = 1 and bit 0 = 1 enters power-down: `powered_down` goes to 1 and all codes read zero. A frame with bit 15 = 1 and bit 0 = 0 leaves power-down. The other bits of such a frame change no register.
- R8: During power-down, data frames and strobes still update the registers. After power-down is left, the outputs show the updated values.
- R9: Falling edges of `ser_clk` while `ser_sel_n` is high shift no data and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; must be slower than a quarter of `clk` |
| ser_sel_n | input | 1 | Active-low frame select and chip enable |
| ser_din | input | 1 | Serial data, MSB first |
| xfer_strobe | input | 1 | One-cycle pulse that copies staging registers to output registers |
| dac_codes | output | 96 | Output codes; channel n is in bits [12n+11:12n] |
| powered_down | output | 1 | High while power-down is active |

## Verification
After `ser_sel_n` rises, a frame's effect is in its register at the fourth rising `clk` edge. The first two edges pass the synchroniser, the third registers the completed frame and the fourth writes the staging register or the power-down flag. An output code follows one edge after a strobe. The bench waits eight cycles after each frame and two cycles after each strobe, then samples one time unit past an edge. Before every strobe it also checks that no output has moved early.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CH_COUNT   = 8;
    localparam int CODE_W     = 12;
    localparam int ADDR_W     = $clog2(CH_COUNT);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int OUT_W      = CH_COUNT * CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    // Frame layout: command flag, channel address, payload
    typedef struct packed {
        logic              is_ctrl;
        logic [ADDR_W-1:0] addr;
        code_t             payload;
    } frame_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_PD_ON,
        CMD_PD_OFF
    } cmd_e;

    // Keep the top res bits of a code and clear the rest
    function automatic code_t res_mask(input int res);
        code_t m;
        m = '1;
        for (int i = 0; i < CODE_W; i++) begin
            if (i < CODE_W - res) m[i] = 1'b0;
        end
        return m;
    endfunction

    function automatic cmd_e classify(input frame_t f);
        if (!f.is_ctrl)       return CMD_WRITE;
        else if (f.payload[0]) return CMD_PD_ON;
        else                  return CMD_PD_OFF;
    endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] prev_q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, stab_q, old_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
                old_q  <= RST_VAL[b];
            end else begin
                meta_q <= async_in[b];
                stab_q <= meta_q;
                old_q  <= stab_q;
            end
        end
        assign sync_q[b] = stab_q;
        assign prev_q[b] = old_q;
    end

endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx
    import dacif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_now,
    input  logic             sclk_old,
    input  logic             sel_now,
    input  logic             sel_old,
    input  logic             din_now,
    output logic             frame_valid,
    output frame_t           frame_word,
    output logic [CNT_W-1:0] bit_count
);

    logic                  fall_edge;
    logic                  sel_rise;
    logic [FRAME_BITS-1:0] shift_q;

    assign fall_edge = sclk_old & ~sclk_now;
    assign sel_rise  = sel_now & ~sel_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_count   <= '0;
            shift_q     <= '0;
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (sel_now) begin
                bit_count <= '0;
                if (sel_rise && bit_count == CNT_W'(FRAME_BITS)) begin
                    frame_valid <= 1'b1;
                    frame_word  <= frame_t'(shift_q);
                end
            end else if (fall_edge && bit_count < CNT_W'(FRAME_BITS)) begin
                shift_q   <= {shift_q[FRAME_BITS-2:0], din_now};
                bit_count <= bit_count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dacif_regbank.sv
module dacif_regbank
    import dacif_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_valid,
    input  frame_t           frame_word,
    input  logic             xfer_strobe,
    output logic [OUT_W-1:0] dac_codes,
    output logic             powered_down
);

    localparam code_t KEEP_MASK = res_mask(RES_BITS);

    cmd_e cmd;

    assign cmd = frame_valid ? classify(frame_word) : CMD_NONE;

    always_ff @(posedge clk) begin
        if (rst)                    powered_down <= 1'b0;
        else if (cmd == CMD_PD_ON)  powered_down <= 1'b1;
        else if (cmd == CMD_PD_OFF) powered_down <= 1'b0;
    end

    for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
        code_t stage_q;
        code_t out_q;
        logic  hit;

        assign hit = (cmd == CMD_WRITE) && (frame_word.addr == ADDR_W'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
                out_q   <= '0;
            end else begin
                if (hit)         stage_q <= frame_word.payload & KEEP_MASK;
                if (xfer_strobe) out_q   <= stage_q;
            end
        end

        assign dac_codes[ch*CODE_W +: CODE_W] = powered_down ? '0 : out_q;
    end

endmodule

// File: rtl/octal_dac_frontend.sv
module octal_dac_frontend
    import dacif_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_sel_n,
    input  logic             ser_din,
    input  logic             xfer_strobe,
    output logic [OUT_W-1:0] dac_codes,
    output logic             powered_down
);

    logic [2:0]       s_now, s_old;
    logic             frame_valid;
    frame_t           frame_word;
    logic [CNT_W-1:0] bit_count;

    // bit 2 = clock, bit 1 = select, bit 0 = data; clock and select idle high
    dacif_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_clk, ser_sel_n, ser_din}),
        .sync_q   (s_now),
        .prev_q   (s_old)
    );

    dacif_frame_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .sclk_now    (s_now[2]),
        .sclk_old    (s_old[2]),
        .sel_now     (s_now[1]),
        .sel_old     (s_old[1]),
        .din_now     (s_now[0]),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .bit_count   (bit_count)
    );

    dacif_regbank #(.RES_BITS(RES_BITS)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .frame_valid  (frame_valid),
        .frame_word   (frame_word),
        .xfer_strobe  (xfer_strobe),
        .dac_codes    (dac_codes),
        .powered_down (powered_down)
    );

endmodule

// File: rtl/octal_dac_frontend_chk.sv
module octal_dac_frontend_chk
    import dacif_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             xfer_strobe,
    input logic             powered_down,
    input logic [OUT_W-1:0] dac_codes,
    input logic             frame_valid,
    input logic [CNT_W-1:0] bit_count
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_codes == '0 && !powered_down));

    // R7
    pd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        powered_down |-> (dac_codes == '0));

    // R5
    hold_codes_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(xfer_strobe) && $stable(powered_down)) |-> $stable(dac_codes));

    // R4
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        bit_count <= CNT_W'(FRAME_BITS));

    // R3
    full_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> ($past(bit_count) == CNT_W'(FRAME_BITS)));

endmodule

bind octal_dac_frontend octal_dac_frontend_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .xfer_strobe  (xfer_strobe),
    .powered_down (powered_down),
    .dac_codes    (dac_codes),
    .frame_valid  (frame_valid),
    .bit_count    (bit_count)
);

// File: tb/octal_dac_frontend_tb.sv
`timescale 1ns/1ps
module octal_dac_frontend_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1, ser_sel_n = 1'b1, ser_din = 1'b0, xfer = 1'b0;
    logic [95:0] codes12, codes10, codes8;
    logic pd12, pd10, pd8;

    int checks = 0;
    int errors = 0;
    logic [11:0] model [8];
    logic pd_model = 1'b0;

    localparam int NVEC = 9;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0FFF, 16'h1001, 16'h2ABC, 16'h3800, 16'h4123,
        16'h5FF3, 16'h6555, 16'h7F0F, 16'h2007
    };

    always #2.5 clk = ~clk;

    octal_dac_frontend #(.RES_BITS(12)) u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .xfer_strobe(xfer), .dac_codes(codes12), .powered_down(pd12));
    octal_dac_frontend #(.RES_BITS(10)) u_dut10 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .xfer_strobe(xfer), .dac_codes(codes10), .powered_down(pd10));
    octal_dac_frontend #(.RES_BITS(8)) u_dut8 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .xfer_strobe(xfer), .dac_codes(codes8), .powered_down(pd8));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // nbits falling edges while select is low; bits past 16 are ones
    task automatic send(input logic [15:0] w, input int nbits);
        ser_sel_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 16) ? w[15-i] : 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(4);
            ser_clk = 1'b1;
        end
        wait_clk(4);
        ser_sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic strobe();
        @(posedge clk); #1 xfer = 1'b1;
        @(posedge clk); #1 xfer = 1'b0;
        wait_clk(2);
    endtask

    task automatic check_all(input string req);
        for (int ch = 0; ch < 8; ch++) begin
            chk(req, 32'(codes12[ch*12 +: 12]), pd_model ? 32'd0 : 32'(model[ch]));
            chk({req, " R6"}, 32'(codes10[ch*12 +: 12]), pd_model ? 32'd0 : 32'(model[ch] & 12'hFFC));
            chk({req, " R6"}, 32'(codes8[ch*12 +: 12]),  pd_model ? 32'd0 : 32'(model[ch] & 12'hFF0));
        end
        chk({req, " pd"}, 32'(pd12), 32'(pd_model));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < 8; ch++) model[ch] = '0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check_all("R1");

        // R2 R5 R6: vector walk
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v], 16);
            check_all("R5 pre-strobe");
            model[VEC[v][14:12]] = VEC[v][11:0];
            strobe();
            check_all("R2");
        end

        // R3: aborted frame, then a full frame restarts cleanly
        send(16'h0123, 10);
        strobe();
        check_all("R3 abort");
        send(16'h1456, 16);
        model[1] = 12'h456;
        strobe();
        check_all("R3 restart");

        // R4: extra edges after the 16th
        send(16'h3A5A, 20);
        model[3] = 12'hA5A;
        strobe();
        check_all("R4");

        // R9: edges with select high
        ser_din = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_clk(4); ser_clk = 1'b0;
            wait_clk(4); ser_clk = 1'b1;
        end
        wait_clk(8);
        strobe();
        check_all("R9");

        // R7: control frame with bit 0 clear while active changes nothing
        send(16'hFFFE, 16);
        strobe();
        check_all("R7 ignore");

        // R7: enter power-down
        send(16'h8001, 16);
        pd_model = 1'b1;
        check_all("R7 on");

        // R8: write during power-down
        send(16'h63AB, 16);
        model[6] = 12'h3AB;
        strobe();
        check_all("R8 hidden");

        // R7 R8: leave power-down
        send(16'h8000, 16);
        pd_model = 1'b0;
        check_all("R8 visible");

        // R1: reset mid-run
        @(posedge clk); #1 rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(2);
        for (int ch = 0; ch < 8; ch++) model[ch] = '0;
        check_all("R1 rerun");
        strobe();
        check_all("R1 staging zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule